// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block collects the end-of-transfer and error events of a multi-channel DMA engine and turns them into interrupt lines and readable status. Each channel engine raises a one-cycle pulse on its terminal-count or error input. The pulse sets a sticky raw bit for that channel. The bit stays set until software clears it by writing a one to the matching position of a write-to-clear register.

The block does not own a mask register. Each channel's 32-bit configuration word is wired in from the channel's own register file, and the block takes three things from it:
- Bit 15 is the terminal-count interrupt enable.
- Bit 14 is the error interrupt enable.
- Bit 0 is the channel-enable flag.

Software reads the raw bits, the masked bits, the combined masked status and the enabled-channel vector at fixed word offsets. Three registered outputs signal terminal count, error and either. The channel count is a parameter. The default is 8, and a reduced build uses 2.

Top module: `dma_irq_agg`

## Requirements
- R1: After a synchronous reset, all raw bits, captured masks, interrupt outputs, `rdata` and `rd_valid` are zero, and every offset reads zero.
- R2: A one-cycle pulse on bit i of `tc_set` or `err_set` sets raw bit i, which then stays set. Raw terminal-count bits read at word offset 5 and raw error bits at word offset 6, with channel i in data bit i.
- R3: The terminal-count mask of channel i is bit 15 of that channel's configuration word, and the error mask is bit 14. The masked terminal-count status reads at offset 1 and the masked error status at offset 3. Each is its raw vector ANDed with its mask.
- R4: Offset 0 reads the OR of the masked terminal-count and masked error vectors.
- R5: A write to offset 2 clears every raw terminal-count bit whose data bit is 1 and keeps the others. A write to offset 4 does the same for raw error bits.
- R6: When a set pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R7: Offset 7 reads a vector with bit i set when bit 0 of channel i's configuration word is 1.
- R8: `irq_tc` is high when the masked terminal-count vector is nonzero, and `irq_err` is high when the masked error vector is nonzero. `irq_any` is their OR. Each output follows the stored state one clock later.
- R9: Reads of offsets other than 0, 1, 3, 5, 6 and 7 return zero. No read changes any state. Writes to offsets other than 2 and 4 have no effect.
- R10: Read data appears on `rdata` with `rd_valid` high exactly one clock after `rd_en` is sampled. Data bits at and above the channel count read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tc_set | input | NUM_CH | Per-channel terminal-count event pulses |
| err_set | input | NUM_CH | Per-channel error event pulses |
| ch_cfg | input | NUM_CH*CFG_W | Channel configuration words, channel i in slice i |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| rd_valid | output | 1 | High for one cycle when `rdata` carries a read result |
| irq_tc | output | 1 | Masked terminal-count interrupt |
| irq_err | output | 1 | Masked error interrupt |
| irq_any | output | 1 | Either interrupt |

## Verification
The hardest case to reach from the ports is a set pulse and a clear write landing on the same channel bit in one clock. In normal traffic the two come from unrelated sources. The bench drives both in the same cycle, on the same bit, on purpose, and then reads the raw register to confirm the set won.

A second hard case is a mask change that silences an interrupt whose raw bit is still pending. The bench reaches it by rewriting a channel's configuration word while raw bits are held. It then checks that `irq_tc` falls while the raw read still shows the bit.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  // Word offsets of the status interface
  typedef enum logic [3:0] {
    OFS_ANY     = 4'd0,
    OFS_TC      = 4'd1,
    OFS_TC_CLR  = 4'd2,
    OFS_ERR     = 4'd3,
    OFS_ERR_CLR = 4'd4,
    OFS_TC_RAW  = 4'd5,
    OFS_ERR_RAW = 4'd6,
    OFS_ENA     = 4'd7
  } ofs_e;

  // Positions inside each channel configuration word
  localparam int unsigned CFG_ENA_BIT    = 0;
  localparam int unsigned CFG_ERR_IE_BIT = 14;
  localparam int unsigned CFG_TC_IE_BIT  = 15;

endpackage

// File: rtl/dma_irq_raw_bank.sv
module dma_irq_raw_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] raw_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           raw_o[i] <= 1'b0;
      else if (set_i[i]) raw_o[i] <= 1'b1;   // set has priority
      else if (clr_i[i]) raw_o[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_irq_cfg_tap.sv
module dma_irq_cfg_tap
  import dma_irq_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N*CFG_W-1:0] cfg_i,
  output logic [N-1:0]     tc_mask_o,
  output logic [N-1:0]     err_mask_o,
  output logic [N-1:0]     ena_o
);

  for (genvar c = 0; c < N; c++) begin : g_ch
    localparam int unsigned BASE = c * CFG_W;
    always_ff @(posedge clk) begin
      if (rst) begin
        tc_mask_o[c]  <= 1'b0;
        err_mask_o[c] <= 1'b0;
        ena_o[c]      <= 1'b0;
      end else begin
        tc_mask_o[c]  <= cfg_i[BASE + CFG_TC_IE_BIT];
        err_mask_o[c] <= cfg_i[BASE + CFG_ERR_IE_BIT];
        ena_o[c]      <= cfg_i[BASE + CFG_ENA_BIT];
      end
    end
  end

endmodule

// File: rtl/dma_irq_rd_mux.sv
module dma_irq_rd_mux
  import dma_irq_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      raw_tc,
  input  logic [N-1:0]      raw_err,
  input  logic [N-1:0]      tc_mask,
  input  logic [N-1:0]      err_mask,
  input  logic [N-1:0]      ena,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);

  logic [N-1:0]      tc_m;
  logic [N-1:0]      err_m;
  logic [N-1:0]      sel;

  assign tc_m  = raw_tc & tc_mask;
  assign err_m = raw_err & err_mask;

  always_comb begin
    case (addr)
      ADDR_W'(OFS_ANY):     sel = tc_m | err_m;
      ADDR_W'(OFS_TC):      sel = tc_m;
      ADDR_W'(OFS_ERR):     sel = err_m;
      ADDR_W'(OFS_TC_RAW):  sel = raw_tc;
      ADDR_W'(OFS_ERR_RAW): sel = raw_err;
      ADDR_W'(OFS_ENA):     sel = ena;
      default:              sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= DATA_W'(sel);
    end
  end

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CFG_W  = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       tc_set,
  input  logic [NUM_CH-1:0]       err_set,
  input  logic [NUM_CH*CFG_W-1:0] ch_cfg,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output logic                    rd_valid,
  output logic                    irq_tc,
  output logic                    irq_err,
  output logic                    irq_any
);

  logic [NUM_CH-1:0] raw_tc;
  logic [NUM_CH-1:0] raw_err;
  logic [NUM_CH-1:0] tc_mask;
  logic [NUM_CH-1:0] err_mask;
  logic [NUM_CH-1:0] ena_vec;
  logic [NUM_CH-1:0] clr_tc;
  logic [NUM_CH-1:0] clr_err;
  logic              wr_tc_clr;
  logic              wr_err_clr;
  logic              unused_in;

  assign unused_in  = ^{wdata, ch_cfg};

  assign wr_tc_clr  = wr_en && (addr == ADDR_W'(OFS_TC_CLR));
  assign wr_err_clr = wr_en && (addr == ADDR_W'(OFS_ERR_CLR));
  assign clr_tc     = wr_tc_clr  ? wdata[NUM_CH-1:0] : '0;
  assign clr_err    = wr_err_clr ? wdata[NUM_CH-1:0] : '0;

  dma_irq_raw_bank #(.N(NUM_CH)) u_tc_bank (
    .clk(clk), .rst(rst), .set_i(tc_set), .clr_i(clr_tc), .raw_o(raw_tc)
  );

  dma_irq_raw_bank #(.N(NUM_CH)) u_err_bank (
    .clk(clk), .rst(rst), .set_i(err_set), .clr_i(clr_err), .raw_o(raw_err)
  );

  dma_irq_cfg_tap #(.N(NUM_CH), .CFG_W(CFG_W)) u_cfg_tap (
    .clk(clk), .rst(rst), .cfg_i(ch_cfg),
    .tc_mask_o(tc_mask), .err_mask_o(err_mask), .ena_o(ena_vec)
  );

  dma_irq_rd_mux #(.N(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_mux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .raw_tc(raw_tc), .raw_err(raw_err), .tc_mask(tc_mask),
    .err_mask(err_mask), .ena(ena_vec),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  // Registered interrupt lines
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tc  <= 1'b0;
      irq_err <= 1'b0;
      irq_any <= 1'b0;
    end else begin
      irq_tc  <= |(raw_tc & tc_mask);
      irq_err <= |(raw_err & err_mask);
      irq_any <= |((raw_tc & tc_mask) | (raw_err & err_mask));
    end
  end

endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] tc_set,
  input logic [NUM_CH-1:0] err_set,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              rd_valid,
  input logic              irq_tc,
  input logic              irq_err,
  input logic              irq_any,
  input logic [NUM_CH-1:0] raw_tc,
  input logic [NUM_CH-1:0] raw_err,
  input logic [NUM_CH-1:0] tc_mask,
  input logic [NUM_CH-1:0] err_mask
);

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((raw_tc & $past(tc_set)) == $past(tc_set)) &&
                     ((raw_err & $past(err_set)) == $past(err_set))));

  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((raw_tc & ~$past(raw_tc) & ~$past(tc_set)) == '0) &&
                     ((raw_err & ~$past(raw_err) & ~$past(err_set)) == '0)));

  // R5 clear effect; the set-over-clear rule (R6) is excluded via tc_set
  assert_tc_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && addr == ADDR_W'(2))) |->
      ((raw_tc & $past(wdata[NUM_CH-1:0]) & ~$past(tc_set)) == '0));

  assert_err_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && addr == ADDR_W'(4))) |->
      ((raw_err & $past(wdata[NUM_CH-1:0]) & ~$past(err_set)) == '0));

  assert_irq_tc_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_tc == |($past(raw_tc & tc_mask))));

  assert_irq_err_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_err == |($past(raw_err & err_mask))));

  assert_irq_any_R8: assert property (@(posedge clk) disable iff (rst)
    irq_any == (irq_tc || irq_err));

  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_valid == $past(rd_en)));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && ($past(addr) > ADDR_W'(7))) |-> (rdata == '0));

endmodule

bind dma_irq_agg dma_irq_agg_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .tc_set(tc_set), .err_set(err_set),
  .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .rd_valid(rd_valid),
  .irq_tc(irq_tc), .irq_err(irq_err), .irq_any(irq_any),
  .raw_tc(raw_tc), .raw_err(raw_err), .tc_mask(tc_mask), .err_mask(err_mask)
);

// File: tb/dma_irq_agg_bench.sv
module dma_irq_agg_bench;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NCH = 8;
  localparam int unsigned CW  = 32;
  localparam int unsigned AW  = 4;
  localparam int unsigned DW  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] tc_set = '0;
  logic [NCH-1:0] err_set = '0;
  logic [NCH*CW-1:0] ch_cfg;
  logic rd_en = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_valid, irq_tc, irq_err, irq_any;

  logic [CW-1:0] cfg_w [NCH];
  logic [NCH-1:0] exp_tc = '0;
  logic [NCH-1:0] exp_err = '0;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) ch_cfg[i*CW +: CW] = cfg_w[i];
  end

  dma_irq_agg #(.NUM_CH(NCH), .CFG_W(CW), .ADDR_W(AW), .DATA_W(DW)) u_dma_irq_agg (
    .clk(clk), .rst(rst), .tc_set(tc_set), .err_set(err_set), .ch_cfg(ch_cfg),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid),
    .irq_tc(irq_tc), .irq_err(irq_err), .irq_any(irq_any)
  );

  function automatic logic [NCH-1:0] tm();
    for (int i = 0; i < NCH; i++) tm[i] = cfg_w[i][15];
  endfunction
  function automatic logic [NCH-1:0] em();
    for (int i = 0; i < NCH; i++) em[i] = cfg_w[i][14];
  endfunction
  function automatic logic [NCH-1:0] en();
    for (int i = 0; i < NCH; i++) en[i] = cfg_w[i][0];
  endfunction

  function automatic logic [DW-1:0] model(int ofs);
    case (ofs)
      0: model = DW'((exp_tc & tm()) | (exp_err & em()));
      1: model = DW'(exp_tc & tm());
      3: model = DW'(exp_err & em());
      5: model = DW'(exp_tc);
      6: model = DW'(exp_err);
      7: model = DW'(en());
      default: model = '0;
    endcase
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read results as the design returns them
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected rd_valid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic rd(int ofs, string req);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(ofs);
    exp_q.push_back(model(ofs));
    tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(int ofs, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(ofs); wdata = d;
    if (ofs == 2) exp_tc  = exp_tc  & ~d[NCH-1:0];
    if (ofs == 4) exp_err = exp_err & ~d[NCH-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(logic [NCH-1:0] t, logic [NCH-1:0] e);
    @(negedge clk);
    tc_set = t; err_set = e;
    exp_tc = exp_tc | t; exp_err = exp_err | e;
    @(negedge clk);
    tc_set = '0; err_set = '0;
  endtask

  task automatic set_cfg(int ch, logic [CW-1:0] w);
    @(negedge clk);
    cfg_w[ch] = w;
    @(negedge clk);
  endtask

  task automatic chk_irq(string req);
    logic [NCH-1:0] mt, me;
    @(negedge clk);
    mt = exp_tc & tm();
    me = exp_err & em();
    check({req, " irq_tc"},  DW'(irq_tc),  DW'(|mt));
    check({req, " irq_err"}, DW'(irq_err), DW'(|me));
    check({req, " irq_any"}, DW'(irq_any), DW'(|(mt | me)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) cfg_w[i] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero by reset
    check("R1 rdata", rdata, '0);
    check("R1 rd_valid", DW'(rd_valid), '0);
    check("R1 irq", DW'({irq_tc, irq_err, irq_any}), '0);
    rst = 1'b0;
    for (int o = 0; o < 8; o++) rd(o, "R1 reset read");

    // R7: enabled-channel vector from config bit 0
    set_cfg(0, 32'h0000_C001);
    set_cfg(3, 32'h0000_8001);
    set_cfg(5, 32'h0000_4000);
    set_cfg(7, 32'h0000_0001);
    rd(7, "R7 enabled vector");
    chk_irq("R8 idle");

    // R2/R3/R4: terminal-count events
    pulse(8'h29, 8'h00);
    rd(5, "R2 raw tc");
    rd(1, "R3 masked tc");
    rd(0, "R4 combined");
    chk_irq("R8 tc pending");

    // Error events
    pulse(8'h00, 8'hA0);
    rd(6, "R2 raw err");
    rd(3, "R3 masked err");
    rd(0, "R4 combined both");
    chk_irq("R8 both pending");

    // R5: write-one-to-clear
    wr(2, 32'h0000_0008);
    rd(5, "R5 tc clear partial");
    rd(1, "R5 masked tc after clear");
    wr(4, 32'h0000_0020);
    rd(6, "R5 err clear");
    rd(3, "R5 masked err after clear");
    chk_irq("R8 err cleared");

    // R6: set and clear on the same bit in the same cycle
    @(negedge clk);
    tc_set = 8'h04; wr_en = 1'b1; addr = AW'(2); wdata = 32'h0000_0004;
    exp_tc = exp_tc | 8'h04;
    @(negedge clk);
    tc_set = '0; wr_en = 1'b0;
    rd(5, "R6 set beats clear");

    // R9: unmapped and write-only offsets, ignored writes
    rd(8, "R9 unmapped 8");
    rd(15, "R9 unmapped 15");
    rd(2, "R9 clear offset reads zero");
    rd(4, "R9 clear offset reads zero");
    wr(9, 32'hFFFF_FFFF);
    wr(5, 32'hFFFF_FFFF);
    rd(5, "R9 raw tc unchanged");
    rd(6, "R9 raw err unchanged");

    // R3/R8: mask removed while raw bit still pending
    set_cfg(0, 32'h0000_0001);
    chk_irq("R8 mask removed");
    rd(5, "R3 raw still held");
    rd(1, "R3 masked after mask change");

    // R10: full clear, upper bits zero
    wr(2, 32'hFFFF_FFFF);
    wr(4, 32'hFFFF_FFFF);
    rd(5, "R10 raw tc empty");
    rd(6, "R10 raw err empty");
    chk_irq("R8 all clear");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R10 missing read data", DW'(exp_q.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule